// File: doc/BRIEF.md
# Load-Linked Reservation Monitor

This block holds the reservation behind a load-linked / store-conditional pair. A load-linked arms a single link flag and records the address it read. Any event that could have broken atomicity drops the flag. Such events are a write by another agent to the same aligned doubleword, reported on a snoop port, and an exception return. When a store-conditional later arrives, the block decides whether the memory write may proceed. It returns the value that the pipeline writes back to the destination register: 1 when the store went through and 0 when it did not.

The core issues the strobes with their addresses. One cycle later the block answers each store-conditional with a store enable, the write-back value, and an address-error flag for misaligned requests. The live state of the reservation is also available as an output. The memory, the coherence protocol and the pipeline stay outside the block.

Top module: `resv_monitor`

## Requirements
- R1: After reset the reservation is clear (`resv_live`=0) and `sc_done`, `sc_store_en`, `sc_addr_err` are 0 and `sc_wb` is 0.
- R2: A cycle with `ll_fire`=1 sets the reservation and records `ll_addr`. `resv_live` reads 1 from the next cycle on.
- R3: A snoop (`snp_valid`=1) whose address lies in the same aligned 8-byte doubleword as the recorded address (address bits above bit 2 equal) clears the reservation. A snoop to any other doubleword leaves it unchanged.
- R4: A cycle with `eret_fire`=1 clears the reservation.
- R5: A store-conditional succeeds only when all of these hold: the reservation is live, its address is in the recorded doubleword, it is aligned, and no clearing event occurs in the same cycle. On success `sc_store_en`=1 and `sc_wb`=1.
- R6: A store-conditional that fails gives `sc_store_en`=0 and `sc_wb`=0. This includes a store-conditional to a different doubleword than the recorded one.
- R7: Every aligned store-conditional clears the reservation afterwards, whether it passed or failed.
- R8: A doubleword store-conditional (`sc_dword`=1) with address bits [2:0] not zero, or a word store-conditional (`sc_dword`=0) with bits [1:0] not zero, gives `sc_addr_err`=1, `sc_store_en`=0 and `sc_wb`=0, and leaves the reservation unchanged.
- R9: Same-cycle ordering: a snoop hit or an exception return in the same cycle as a store-conditional makes it fail. A load-linked in the same cycle as any clearing event leaves the reservation set.
- R10: The outcome of a store-conditional appears on the cycle after `sc_fire`, with `sc_done`=1 for exactly that one cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ll_fire | input | 1 | Load-linked strobe |
| ll_addr | input | AW | Load-linked address |
| sc_fire | input | 1 | Store-conditional strobe |
| sc_addr | input | AW | Store-conditional address |
| sc_dword | input | 1 | 1 = doubleword store, 0 = word store |
| snp_valid | input | 1 | External write observed |
| snp_addr | input | AW | Address of the external write |
| eret_fire | input | 1 | Exception-return strobe |
| sc_done | output | 1 | Store-conditional outcome valid |
| sc_store_en | output | 1 | Memory write may proceed |
| sc_wb | output | DW | Register write-back value (1 or 0) |
| sc_addr_err | output | 1 | Store-conditional misaligned |
| resv_live | output | 1 | Reservation currently armed |

## Verification
A corrupted link flag or a stale recorded address does not stay hidden for long. The next store-conditional shows it as a wrong `sc_store_en` and `sc_wb` one cycle after its strobe. It also shows on `resv_live` in the very next cycle. If the recorded address is wrong, a snoop to the true line fails to clear the reservation, or a snoop to another line clears it. Both show up as a `resv_live` mismatch one cycle after the snoop. Random traffic over a handful of doublewords makes such hits and near misses frequent. The same-cycle collisions are also driven directly.

// File: rtl/resv_pkg.sv
package resv_pkg;
  typedef enum logic [1:0] {
    SC_NONE = 2'd0,
    SC_PASS = 2'd1,
    SC_FAIL = 2'd2,
    SC_AERR = 2'd3
  } sc_outcome_e;
endpackage

// File: rtl/resv_align.sv
module resv_align #(
  parameter int GL = 3
) (
  input  logic [GL-1:0] low,
  input  logic          dword,
  output logic          misal
);
  function automatic logic is_misaligned(input logic [GL-1:0] lo, input logic dw);
    if (dw) return (lo != '0);
    return (lo[GL-2:0] != '0);
  endfunction

  assign misal = is_misaligned(low, dword);
endmodule

// File: rtl/resv_cmp.sv
module resv_cmp #(
  parameter int AW = 32,
  parameter int GL = 3
) (
  input  logic [AW-1:0] a,
  input  logic [AW-1:0] b,
  output logic          hit
);
  function automatic logic same_granule(input logic [AW-1:0] x, input logic [AW-1:0] y);
    logic [AW-1:0] diff;
    diff = x ^ y;
    return ((diff >> GL) == '0);
  endfunction

  assign hit = same_granule(a, b);
endmodule

// File: rtl/resv_monitor.sv
module resv_monitor #(
  parameter int AW = 32,
  parameter int DW = 64
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          ll_fire,
  input  logic [AW-1:0] ll_addr,
  input  logic          sc_fire,
  input  logic [AW-1:0] sc_addr,
  input  logic          sc_dword,
  input  logic          snp_valid,
  input  logic [AW-1:0] snp_addr,
  input  logic          eret_fire,
  output logic          sc_done,
  output logic          sc_store_en,
  output logic [DW-1:0] sc_wb,
  output logic          sc_addr_err,
  output logic          resv_live
);
  import resv_pkg::*;

  localparam int GL = $clog2(DW / 8);

  logic          link_q;
  logic [AW-1:0] addr_q;
  sc_outcome_e   outcome_q;
  sc_outcome_e   outcome_d;

  // named internal events
  logic snp_hit;
  logic sc_hit;
  logic sc_misal;
  logic kill_now;
  logic sc_exec;
  logic sc_pass;
  logic link_d;

  resv_cmp #(.AW(AW), .GL(GL)) u_snp_cmp (.a(addr_q), .b(snp_addr), .hit(snp_hit));
  resv_cmp #(.AW(AW), .GL(GL)) u_sc_cmp  (.a(addr_q), .b(sc_addr),  .hit(sc_hit));
  resv_align #(.GL(GL)) u_align (.low(sc_addr[GL-1:0]), .dword(sc_dword), .misal(sc_misal));

  assign kill_now = eret_fire | (snp_valid & snp_hit & link_q);
  assign sc_exec  = sc_fire & ~sc_misal;
  assign sc_pass  = sc_exec & link_q & sc_hit & ~kill_now;

  always_comb begin
    if (!sc_fire)      outcome_d = SC_NONE;
    else if (sc_misal) outcome_d = SC_AERR;
    else if (sc_pass)  outcome_d = SC_PASS;
    else               outcome_d = SC_FAIL;
  end

  always_comb begin
    if (ll_fire)                  link_d = 1'b1;
    else if (sc_exec || kill_now) link_d = 1'b0;
    else                          link_d = link_q;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      link_q    <= 1'b0;
      addr_q    <= '0;
      outcome_q <= SC_NONE;
    end else begin
      link_q    <= link_d;
      outcome_q <= outcome_d;
      if (ll_fire) addr_q <= ll_addr;
    end
  end

  assign resv_live   = link_q;
  assign sc_done     = (outcome_q != SC_NONE);
  assign sc_store_en = (outcome_q == SC_PASS);
  assign sc_addr_err = (outcome_q == SC_AERR);
  assign sc_wb       = {{(DW-1){1'b0}}, (outcome_q == SC_PASS)};

  // R2
  ll_sets_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ll_fire |=> resv_live);

  // R4
  eret_drops_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (eret_fire && !ll_fire) |=> !resv_live);

  // R5
  pass_needs_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_fire && !resv_live) |=> !sc_store_en);

  // R7
  sc_clears_link_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sc_fire && !sc_misal && !ll_fire) |=> !resv_live);

  // R8
  aerr_no_store_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_addr_err |-> (!sc_store_en && sc_wb == '0));

  // R10
  done_follows_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sc_fire |=> sc_done);

  // R10
  done_only_after_sc_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sc_fire |=> !sc_done);
endmodule

// File: tb/sim_resv_monitor.sv
module sim_resv_monitor;
  localparam int AW = 32;
  localparam int DW = 64;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          ll_fire = 1'b0;
  logic [AW-1:0] ll_addr = '0;
  logic          sc_fire = 1'b0;
  logic [AW-1:0] sc_addr = '0;
  logic          sc_dword = 1'b0;
  logic          snp_valid = 1'b0;
  logic [AW-1:0] snp_addr = '0;
  logic          eret_fire = 1'b0;
  logic          sc_done;
  logic          sc_store_en;
  logic [DW-1:0] sc_wb;
  logic          sc_addr_err;
  logic          resv_live;

  int tests = 0;
  int fails = 0;
  bit finished = 1'b0;

  // bench model
  logic          m_link = 1'b0;
  logic [AW-1:0] m_addr = '0;
  logic          e_done = 1'b0, e_wen = 1'b0, e_aerr = 1'b0, e_link = 1'b0;
  string         t_out = "R1", t_link = "R1";

  always #4 clk = ~clk;

  resv_monitor #(.AW(AW), .DW(DW)) u0 (
    .clk(clk), .rst_n(rst_n), .ll_fire(ll_fire), .ll_addr(ll_addr),
    .sc_fire(sc_fire), .sc_addr(sc_addr), .sc_dword(sc_dword),
    .snp_valid(snp_valid), .snp_addr(snp_addr), .eret_fire(eret_fire),
    .sc_done(sc_done), .sc_store_en(sc_store_en), .sc_wb(sc_wb),
    .sc_addr_err(sc_addr_err), .resv_live(resv_live));

  function automatic logic same_line(input logic [AW-1:0] x, input logic [AW-1:0] y);
    return (x / 8) == (y / 8);
  endfunction

  function automatic logic bad_align(input logic [AW-1:0] a, input logic dw);
    return dw ? ((a % 8) != 0) : ((a % 4) != 0);
  endfunction

  task automatic check1(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
    end
  endtask

  task automatic check_all();
    check1("R10", "sc_done", DW'(sc_done), DW'(e_done));
    check1("R8", "sc_addr_err", DW'(sc_addr_err), DW'(e_aerr));
    check1(t_out, "sc_store_en", DW'(sc_store_en), DW'(e_wen));
    check1(t_out, "sc_wb", sc_wb, DW'(e_wen));
    check1(t_link, "resv_live", DW'(resv_live), DW'(e_link));
  endtask

  task automatic step(input logic ll, input logic [AW-1:0] la,
                      input logic sc, input logic [AW-1:0] sa, input logic dw,
                      input logic sv, input logic [AW-1:0] na, input logic er);
    logic kill, mis, nl;
    @(negedge clk);
    check_all();
    ll_fire = ll; ll_addr = la; sc_fire = sc; sc_addr = sa; sc_dword = dw;
    snp_valid = sv; snp_addr = na; eret_fire = er;
    kill   = er || (sv && m_link && same_line(na, m_addr));
    mis    = sc && bad_align(sa, dw);
    e_done = sc;
    e_aerr = mis;
    e_wen  = sc && !mis && m_link && same_line(sa, m_addr) && !kill;
    if (sc && kill) t_out = "R9";
    else if (e_wen) t_out = "R5";
    else            t_out = "R6";
    if (ll)                   nl = 1'b1;
    else if ((sc && !mis) || kill) nl = 1'b0;
    else                      nl = m_link;
    if (ll && (kill || sc))   t_link = "R9";
    else if (ll)              t_link = "R2";
    else if (er)              t_link = "R4";
    else if (sv)              t_link = "R3";
    else if (sc)              t_link = mis ? "R8" : "R7";
    else                      t_link = "R2";
    if (ll) m_addr = la;
    m_link = nl;
    e_link = nl;
  endtask

  task automatic idle();
    step(0, '0, 0, '0, 0, 0, '0, 0);
  endtask

  localparam logic [AW-1:0] A = 32'h0000_1040;
  localparam logic [AW-1:0] B = 32'h0000_2080;

  initial begin
    void'($urandom(32'h5EED_0017));
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset state
    check1("R1", "resv_live", DW'(resv_live), '0);
    check1("R1", "sc_done", DW'(sc_done), '0);
    check1("R1", "sc_store_en", DW'(sc_store_en), '0);
    check1("R1", "sc_wb", sc_wb, '0);

    // R2 R5: arm then pass
    step(1, A, 0, '0, 0, 0, '0, 0);
    step(0, '0, 1, A, 1, 0, '0, 0);
    // R6 R7: second store fails
    step(0, '0, 1, A, 1, 0, '0, 0);
    // R3: snoop inside the same doubleword kills
    step(1, A, 0, '0, 0, 0, '0, 0);
    step(0, '0, 0, '0, 0, 1, A + 4, 0);
    step(0, '0, 1, A, 1, 0, '0, 0);
    // R3: snoop elsewhere has no effect
    step(1, A, 0, '0, 0, 0, '0, 0);
    step(0, '0, 0, '0, 0, 1, A + 8, 0);
    step(0, '0, 1, A, 1, 0, '0, 0);
    // R4: exception return kills
    step(1, A, 0, '0, 0, 0, '0, 0);
    step(0, '0, 0, '0, 0, 0, '0, 1);
    step(0, '0, 1, A, 0, 0, '0, 0);
    // R8: misaligned word, link kept, then pass
    step(1, A, 0, '0, 0, 0, '0, 0);
    step(0, '0, 1, A + 2, 0, 0, '0, 0);
    step(0, '0, 1, A + 4, 1, 0, '0, 0);
    step(0, '0, 1, A + 4, 0, 0, '0, 0);
    // R9: snoop in same cycle as SC
    step(1, A, 0, '0, 0, 0, '0, 0);
    step(0, '0, 1, A, 1, 1, A, 0);
    // R9: LL with eret and snoop in same cycle keeps link
    step(1, B, 0, '0, 0, 1, B, 1);
    step(0, '0, 1, B, 1, 0, '0, 0);
    // R6: mismatched address
    step(1, A, 0, '0, 0, 0, '0, 0);
    step(0, '0, 1, B, 1, 0, '0, 0);
    idle();

    // random traffic on a few doublewords
    for (int i = 0; i < 4000; i++) begin
      logic [AW-1:0] la, sa, na;
      la = 32'h1000 + (($urandom % 4) * 8) + ($urandom % 8);
      sa = 32'h1000 + (($urandom % 4) * 8) + (($urandom % 4 == 0) ? ($urandom % 8) : (($urandom % 2) * 4));
      na = 32'h1000 + (($urandom % 4) * 8) + ($urandom % 8);
      step(($urandom % 4) == 0, la, ($urandom % 3) == 0, sa, $urandom % 2,
           ($urandom % 5) == 0, na, ($urandom % 12) == 0);
    end
    idle();
    idle();
    finished = 1'b1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule